// File: doc/BRIEF.md
# Remote host write controller with instruction byte assembly

This block lets an external host write into the data memory, the instruction memory or the program counter of an embedded processor whose buses it shares. The host raises a single write request (remote enable already combined with its write strobe) along with a two-bit target code, a command bit and a data byte. The controller takes the buses from the local processor, gives the address one clock to settle, and drives the write strobe for the target. It stretches that strobe by the programmed wait count, signals completion on `xack`, and then hands the buses back. Instruction words are 16 bits wide but arrive one byte at a time, low byte first. The first byte is parked in a holding register. The second byte triggers the instruction-memory write of the whole word and a program-counter increment.

The host interface is a request/acknowledge handshake rather than a stream. `xack` low means "not yet done" and acts as back-pressure: the host must keep `host_wr`, `mem_sel`, `cmd` and `host_byte` steady until `xack` returns high. In slow mode the controller also waits for the host to drop `host_wr` before it releases the buses. In fast mode it releases them on its own and ignores the still-high request until that request has been withdrawn. A local bus request always wins while the controller is idle. A local request that arrives during a remote access is remembered and granted when the controller returns to idle. A lock-out input keeps remote requests from starting at all.

Top module: `rhost_wr_ctl`

## Requirements
- R1: After reset, `xack` and `local_own` are high, `bus_hiz`, all write strobes, `pc_inc` and `loc_gnt` are low, and the instruction byte flag is 0, so the first instruction-memory write only fills the holding register.
- R2: With `cmd` = 0, `mem_sel` = 2'b10 drives `pc_lo_ld` and `mem_sel` = 2'b11 drives `pc_hi_ld` for exactly one cycle, with `ld_byte` equal to the host byte. With `cmd` = 1, neither strobe fires, but the access is still acknowledged.
- R3: `mem_sel` = 2'b00 drives `dmem_we` for 1 + `dmem_wait` cycles, with `bus_hiz` high throughout.
- R4: `mem_sel` = 2'b01 with the byte flag at 0 stores the byte and raises no `imem_we`. With the flag at 1, `imem_we` is high for 1 + `imem_wait` cycles and `instr_word` carries {this byte, held byte} (bits 15:8 new, bits 7:0 held).
- R5: The byte flag toggles at the end of every instruction-memory access. `pc_inc` pulses for one cycle, in the release cycle, only after a high-byte write.
- R6: Between accepting a request and raising any write strobe there is exactly one settle cycle, with `local_own` low, `xack` low and no strobe.
- R7: `xack` returns high in the same cycle that the write strobe drops. In fast mode `local_own` returns high one cycle later.
- R8: In slow mode `local_own` stays low while `host_wr` remains high after `xack`, and it returns high one cycle after `host_wr` drops. In either mode a request left high after completion does not start a second access.
- R9: While `lock_out` is high, no remote access starts (`bus_hiz` stays low, `xack` stays high), and local requests are still granted.
- R10: A local request in idle is granted at once and holds off a pending remote request. A local request pulsed during a remote access is not granted then, but is granted on the first idle cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_wr | input | 1 | remote write request (enable AND write strobe) |
| lock_out | input | 1 | blocks remote accesses when high |
| fast_mode | input | 1 | 1: terminate without waiting for request removal |
| mem_sel | input | 2 | target: 00 data mem, 01 instr mem, 10 PC low, 11 PC high |
| cmd | input | 1 | command bit; must be 0 for PC loads |
| host_byte | input | 8 | byte written by the host |
| dmem_wait | input | WAIT_W | data memory wait states |
| imem_wait | input | WAIT_W | instruction memory wait states |
| loc_req | input | 1 | local processor bus request |
| xack | output | 1 | low while host must wait |
| local_own | output | 1 | local processor owns the buses |
| bus_hiz | output | 1 | address/data drivers tri-stated |
| dmem_we | output | 1 | data memory write strobe |
| imem_we | output | 1 | instruction memory write strobe |
| instr_word | output | 16 | assembled instruction word |
| pc_lo_ld | output | 1 | load PC low byte |
| pc_hi_ld | output | 1 | load PC high byte |
| ld_byte | output | 8 | byte captured for PC loads |
| pc_inc | output | 1 | increment PC |
| loc_gnt | output | 1 | local bus grant |

## Verification
The bench pairs a low-byte and a high-byte instruction write and checks the assembled word. A design that wrote instruction memory on the first byte, or swapped the byte halves, would fail that check. It leaves the request high after a fast-mode completion to catch a controller that restarts a second access. It also holds the request for several cycles in slow mode to catch one that releases the buses early. It pulses a local request in the middle of a long access and looks for the grant only on return to idle, which exposes a lost or premature grant. Random targets, wait counts and modes then measure the strobe length and the relative timing of `xack` and `local_own` on every access.

// File: rtl/rhw_pkg.sv
package rhw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_ACC    = 3'd2,
    ST_TERM   = 3'd3,
    ST_REL    = 3'd4
  } rhw_state_e;

  typedef enum logic [1:0] {
    SEL_DMEM = 2'b00,
    SEL_IMEM = 2'b01,
    SEL_PCLO = 2'b10,
    SEL_PCHI = 2'b11
  } rhw_sel_e;
endpackage

// File: rtl/rhw_seq.sv
module rhw_seq
  import rhw_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              lock_out,
  input  logic              fast_mode,
  input  logic              loc_busy,
  input  logic [1:0]        mem_sel,
  input  logic              cmd,
  input  logic [WAIT_W-1:0] dmem_wait,
  input  logic [WAIT_W-1:0] imem_wait,
  output rhw_state_e        state,
  output rhw_sel_e          sel_q,
  output logic              cmd_q,
  output logic              req_wait
);
  rhw_state_e        nxt;
  logic [WAIT_W-1:0] cnt;
  logic              done_hold;
  logic              start;

  // a request counts only if it was not already served
  assign req_wait = (state == ST_IDLE) && host_wr && !done_hold && !lock_out;
  assign start    = req_wait && !loc_busy;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_SETTLE;
      ST_SETTLE: nxt = ST_ACC;
      ST_ACC:    if (cnt == '0) nxt = ST_TERM;
      ST_TERM:   if (fast_mode || !host_wr) nxt = ST_REL;
      ST_REL:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sel_q     <= SEL_DMEM;
      cmd_q     <= 1'b0;
      cnt       <= '0;
      done_hold <= 1'b0;
    end else begin
      state     <= nxt;
      done_hold <= host_wr && ((state == ST_REL) || done_hold);
      if (start) begin
        sel_q <= rhw_sel_e'(mem_sel);
        cmd_q <= cmd;
      end
      if (state == ST_SETTLE) begin
        unique case (sel_q)
          SEL_DMEM: cnt <= dmem_wait;
          SEL_IMEM: cnt <= imem_wait;
          default:  cnt <= '0;
        endcase
      end else if (state == ST_ACC && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rhw_ilat.sv
module rhw_ilat #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                capture_imem,
  input  logic                release_imem,
  input  logic [BYTE_W-1:0]   host_byte,
  output logic                hi_flag,
  output logic [2*BYTE_W-1:0] instr_word,
  output logic [BYTE_W-1:0]   ld_byte,
  output logic                pc_inc
);
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      ld_byte <= '0;
      hi_flag <= 1'b0;
    end else begin
      if (capture) ld_byte <= host_byte;
      if (capture_imem) begin
        if (hi_flag) hi_q <= host_byte;
        else         lo_q <= host_byte;
      end
      if (release_imem) hi_flag <= ~hi_flag;
    end
  end

  assign instr_word = {hi_q, lo_q};
  assign pc_inc     = release_imem && hi_flag;
endmodule

// File: rtl/rhw_arb.sv
module rhw_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_req,
  input  logic idle,
  output logic loc_busy,
  output logic loc_gnt
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (idle) pend <= 1'b0;
    else           pend <= pend | loc_req;
  end

  assign loc_busy = loc_req | pend;
  assign loc_gnt  = idle && loc_busy;
endmodule

// File: rtl/rhost_wr_ctl.sv
module rhost_wr_ctl
  import rhw_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                lock_out,
  input  logic                fast_mode,
  input  logic [1:0]          mem_sel,
  input  logic                cmd,
  input  logic [BYTE_W-1:0]   host_byte,
  input  logic [WAIT_W-1:0]   dmem_wait,
  input  logic [WAIT_W-1:0]   imem_wait,
  input  logic                loc_req,
  output logic                xack,
  output logic                local_own,
  output logic                bus_hiz,
  output logic                dmem_we,
  output logic                imem_we,
  output logic [2*BYTE_W-1:0] instr_word,
  output logic                pc_lo_ld,
  output logic                pc_hi_ld,
  output logic [BYTE_W-1:0]   ld_byte,
  output logic                pc_inc,
  output logic                loc_gnt
);
  rhw_state_e state;
  rhw_sel_e   sel_q;
  logic       cmd_q;
  logic       req_wait;
  logic       loc_busy;
  logic       hi_flag;
  logic       in_acc;

  rhw_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .lock_out(lock_out),
    .fast_mode(fast_mode), .loc_busy(loc_busy), .mem_sel(mem_sel), .cmd(cmd),
    .dmem_wait(dmem_wait), .imem_wait(imem_wait), .state(state),
    .sel_q(sel_q), .cmd_q(cmd_q), .req_wait(req_wait)
  );

  rhw_ilat #(.BYTE_W(BYTE_W)) u_ilat (
    .clk(clk), .rst_n(rst_n),
    .capture(state == ST_SETTLE),
    .capture_imem((state == ST_SETTLE) && (sel_q == SEL_IMEM)),
    .release_imem((state == ST_REL) && (sel_q == SEL_IMEM)),
    .host_byte(host_byte), .hi_flag(hi_flag), .instr_word(instr_word),
    .ld_byte(ld_byte), .pc_inc(pc_inc)
  );

  rhw_arb u_arb (
    .clk(clk), .rst_n(rst_n), .loc_req(loc_req),
    .idle(state == ST_IDLE), .loc_busy(loc_busy), .loc_gnt(loc_gnt)
  );

  assign in_acc    = (state == ST_ACC);
  assign xack      = !(req_wait || state == ST_SETTLE || in_acc);
  assign local_own = (state == ST_IDLE) || (state == ST_REL);
  assign bus_hiz   = (state != ST_IDLE);
  assign dmem_we   = in_acc && (sel_q == SEL_DMEM);
  assign imem_we   = in_acc && (sel_q == SEL_IMEM) && hi_flag;
  assign pc_lo_ld  = in_acc && (sel_q == SEL_PCLO) && !cmd_q;
  assign pc_hi_ld  = in_acc && (sel_q == SEL_PCHI) && !cmd_q;
endmodule

// File: rtl/rhost_wr_ctl_chk.sv
module rhost_wr_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_out,
  input logic xack,
  input logic local_own,
  input logic bus_hiz,
  input logic dmem_we,
  input logic imem_we,
  input logic pc_lo_ld,
  input logic pc_hi_ld,
  input logic pc_inc,
  input logic loc_gnt
);
  logic any_we;
  assign any_we = dmem_we | imem_we | pc_lo_ld | pc_hi_ld;

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dmem_we, imem_we, pc_lo_ld, pc_hi_ld}));

  p_settle_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_we) |-> ($past(!local_own) && $past(!xack)));

  p_ack_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_we) |-> (xack && !local_own));

  p_pcinc_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |-> (local_own && bus_hiz && $past(!local_own)));

  p_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_out && !bus_hiz) |=> !bus_hiz);

  p_grant_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_gnt |-> (local_own && !bus_hiz));
endmodule

bind rhost_wr_ctl rhost_wr_ctl_chk u_chk (.*);

// File: tb/rhost_wr_ctl_tb.sv
module rhost_wr_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, lock_out = 1'b0, fast_mode = 1'b0, cmd = 1'b0, loc_req = 1'b0;
  logic [1:0]  mem_sel = 2'b00;
  logic [7:0]  host_byte = 8'h00;
  logic [3:0]  dmem_wait = 4'd0, imem_wait = 4'd0;
  logic        xack, local_own, bus_hiz, dmem_we, imem_we, pc_lo_ld, pc_hi_ld, pc_inc, loc_gnt;
  logic [15:0] instr_word;
  logic [7:0]  ld_byte;

  int  n_tests = 0, n_fail = 0;
  bit  m_hi = 1'b0;
  logic [7:0] m_lo = 8'h00;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  rhost_wr_ctl u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] exp_strobes(input logic [1:0] s, input logic c, input bit hi);
    return {s == 2'b00, s == 2'b01 && hi, s == 2'b10 && !c, s == 2'b11 && !c};
  endfunction

  task automatic xfer(input logic [1:0] s, input logic c, input logic [7:0] b,
                      input logic fm, input int dw, input int iw, input int hold);
    int n;
    int expw;
    logic [3:0] es;
    @(negedge clk);
    host_wr = 1; mem_sel = s; cmd = c; host_byte = b; fast_mode = fm;
    dmem_wait = 4'(dw); imem_wait = 4'(iw);
    step();
    chk(!xack && !local_own && bus_hiz &&
        {dmem_we, imem_we, pc_lo_ld, pc_hi_ld} == 4'b0, "R6 settle", {xack, local_own}, 0);
    expw = (s == 2'b00) ? dw : (s == 2'b01) ? iw : 0;
    es = exp_strobes(s, c, m_hi);
    n = 0;
    step();
    while (!xack && n < 40) begin
      chk({dmem_we, imem_we, pc_lo_ld, pc_hi_ld} == es && bus_hiz, "R2/R3/R4 strobe",
          {dmem_we, imem_we, pc_lo_ld, pc_hi_ld}, es);
      if (s == 2'b01 && m_hi) chk(instr_word == {b, m_lo}, "R4 word", instr_word, {b, m_lo});
      if (s[1] && !c) chk(ld_byte == b, "R2 pc byte", ld_byte, b);
      n++;
      step();
    end
    chk(n == expw + 1, "R2/R3/R4 strobe length", n, expw + 1);
    chk(!local_own && {dmem_we, imem_we, pc_lo_ld, pc_hi_ld} == 4'b0, "R7 ack with strobe end",
        local_own, 0);
    if (!fm) begin
      for (int k = 0; k < hold; k++) begin
        step();
        chk(!local_own && xack, "R8 slow hold", local_own, 0);
      end
      @(negedge clk); host_wr = 0;
      step();
      chk(local_own, "R8 slow release", local_own, 1);
    end else begin
      step();
      chk(local_own, "R7 fast release", local_own, 1);
    end
    chk(pc_inc == (s == 2'b01 && m_hi), "R5 pc_inc", pc_inc, (s == 2'b01 && m_hi));
    if (s == 2'b01) begin
      if (!m_hi) m_lo = b;
      m_hi = !m_hi;
    end
    step();
    if (fm) begin
      chk(xack && local_own && !bus_hiz, "R8 no re-entry", bus_hiz, 0);
      @(negedge clk); host_wr = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(xack && local_own && !bus_hiz && !dmem_we && !imem_we && !pc_lo_ld && !pc_hi_ld
        && !pc_inc && !loc_gnt, "R1 reset", {xack, local_own, bus_hiz}, 3'b110);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step();

    // R4/R5 directed: low byte then high byte
    xfer(2'b01, 0, 8'h3c, 1, 0, 2, 0);
    xfer(2'b01, 0, 8'ha5, 0, 0, 3, 2);
    // R2 directed: PC loads and ignored cmd
    xfer(2'b10, 0, 8'h11, 1, 0, 0, 0);
    xfer(2'b11, 0, 8'h22, 0, 0, 0, 1);
    xfer(2'b10, 1, 8'h33, 1, 0, 0, 0);
    // R3 directed: long data wait
    xfer(2'b00, 0, 8'h44, 0, 15, 0, 3);

    // R9 lock-out
    @(negedge clk); lock_out = 1; host_wr = 1; loc_req = 1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(!bus_hiz && xack && loc_gnt, "R9 lock-out", {bus_hiz, xack, loc_gnt}, 3'b011);
    end
    @(negedge clk); lock_out = 0; loc_req = 0; host_wr = 0;
    step();

    // R10 local request in idle holds off a remote request
    @(negedge clk); loc_req = 1; host_wr = 1;
    step();
    chk(local_own && !bus_hiz && loc_gnt && !xack, "R10 idle grant", {local_own, bus_hiz, loc_gnt}, 3'b101);
    @(negedge clk); loc_req = 0; host_wr = 0;
    step();

    // R10 local pulse during access, granted on return to idle
    fork
      xfer(2'b00, 0, 8'h55, 1, 4, 0, 0);
      begin
        repeat (3) @(negedge clk);
        loc_req = 1;
        @(negedge clk); loc_req = 0;
        chk(!loc_gnt, "R10 no grant in access", loc_gnt, 0);
      end
    join
    chk(loc_gnt, "R10 pending grant", loc_gnt, 1);
    step();
    chk(!loc_gnt, "R10 grant once", loc_gnt, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      xfer(2'($urandom), 1'($urandom_range(0, 3) == 0), 8'($urandom), 1'($urandom),
           $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 3));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule